// File: doc/BRIEF.md
# Latched MAC Event Status Word

This block presents one 52-bit read-only status word for a network MAC channel. Single-cycle event strobes from the transmit DMA, the receive and transmit FIFOs, the collision path and the statistics counters set sticky flags. The flags hold until software reads the word. A read strobe clears every sticky flag on the next clock edge. Two watermark bits are not stored. They are live comparisons of the current descriptor count against two thresholds, so a read never changes them.

A small collision tracker sits inside the block. It has three named states:
- `CT_IDLE`: no packet is in flight.
- `CT_SEND`: a packet is being attempted.
- `CT_GAVEUP`: the collision limit has been hit.

The transitions are:
- `tx_start` moves `CT_IDLE` or `CT_GAVEUP` to `CT_SEND`. In `CT_SEND` it restarts the count.
- `pkt_end` moves `CT_SEND` or `CT_GAVEUP` back to `CT_IDLE`.
- The collision that reaches the limit moves `CT_SEND` to `CT_GAVEUP`.

Only collisions seen in `CT_SEND` count and can be flagged as late. When a statistics counter overflows, the block sets an overflow flag and keeps the 5-bit index of the most recent counter that overflowed.

Top module: `mac_evt_status`

## Requirements
- R1: After reset every bit of `status` is 0.
- R2: Bits 39:32, bits 31:9 and bits 45:40 always read 0.
- R3: A `pkt_end` strobe sets bit 0 from the next edge on, and bit 0 stays set until a read clears it.
- R4: Bit 1 is 1 exactly while `dscr_cnt < hwm_lvl`, and bit 2 is 1 exactly while `dscr_cnt < lwm_lvl`. Equality gives 0. A read does not change either bit.
- R5: The strobes `rxf_under`, `rxf_over`, `txf_under` and `txf_over` set sticky bits 3, 4, 5 and 6 respectively.
- R6: A `col_det` strobe in `CT_SEND` while `past_min` is 1 sets sticky bit 7. With `past_min` at 0 it does not set bit 7.
- R7: The 16th collision counted since the last `tx_start` sets sticky bit 8. Fifteen collisions do not set it. A new `tx_start` restarts the count.
- R8: A `ctr_ovf` strobe sets bit 46 and loads `ctr_idx` into bits 51:47. A later overflow overwrites the field. Bits 51:47 are 0 whenever bit 46 is 0.
- R9: A `rd_stb` clears every sticky bit and the index field at the next edge. An event arriving in the same cycle as the read leaves its bit set, and for an overflow it leaves the new index in place.
- R10: Collisions outside a packet (in `CT_IDLE`, before `tx_start` or after `pkt_end`) neither count toward R7 nor set bit 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_stb | input | 1 | Status read; clears the sticky bits |
| pkt_end | input | 1 | End of a packet transfer |
| tx_start | input | 1 | Start of a packet transmission |
| dscr_cnt | input | DSCR_W | Current descriptor count |
| hwm_lvl | input | DSCR_W | High watermark threshold |
| lwm_lvl | input | DSCR_W | Low watermark threshold |
| rxf_under | input | 1 | Receive FIFO underflow strobe |
| rxf_over | input | 1 | Receive FIFO overflow strobe |
| txf_under | input | 1 | Transmit FIFO underflow strobe |
| txf_over | input | 1 | Transmit FIFO overflow strobe |
| col_det | input | 1 | Collision detected on the current attempt |
| past_min | input | 1 | Minimum frame size already sent |
| ctr_ovf | input | 1 | A statistics counter overflowed |
| ctr_idx | input | 5 | Index of the overflowing counter |
| status | output | 52 | Status word |

## Verification
The sticky bits are tried three ways: with isolated strobes, with strobes that accumulate across several cycles before one read, and with a strobe that coincides with a read. Together these separate a plain register, a clear-on-read flag and a flag that loses an event arriving during a read. Collision runs of exactly 15 and 16 strikes show where the limit falls. A count interrupted by `tx_start`, and strikes outside any packet, show whether the tracker restarts and whether it gates on packet state. The watermark bits are driven with counts below, equal to and above each threshold, and are also read back after a read. This separates a strict from a non-strict comparison and a live bit from a latched one. Two overflows in a row, and an overflow during a read, show whether the index field is overwritten and whether it survives a read.

// File: rtl/mac_evt_status_pkg.sv
package mac_evt_status_pkg;
    localparam int STAT_W  = 52;
    localparam int IDX_W   = 5;
    localparam int IDX_LO  = 47;
    localparam int B_EOP   = 0;
    localparam int B_HWM   = 1;
    localparam int B_LWM   = 2;
    localparam int B_RXU   = 3;
    localparam int B_RXO   = 4;
    localparam int B_TXU   = 5;
    localparam int B_TXO   = 6;
    localparam int B_LATE  = 7;
    localparam int B_EXC   = 8;
    localparam int B_CTR   = 46;
    localparam int N_STICKY = 7;

    typedef enum logic [1:0] {
        CT_IDLE   = 2'd0,
        CT_SEND   = 2'd1,
        CT_GAVEUP = 2'd2
    } ct_state_t;
endpackage

// File: rtl/sticky_flags.sv
module sticky_flags #(
    parameter int N = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] evt,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= 1'b0;
            else
                q[i] <= evt[i] | (q[i] & ~clr);
        end
    end
endmodule

// File: rtl/ovf_capture.sv
module ovf_capture
    import mac_evt_status_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ovf,
    input  logic [IDX_W-1:0] idx,
    output logic             flag,
    output logic [IDX_W-1:0] idx_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag  <= 1'b0;
            idx_q <= '0;
        end else if (ovf) begin
            flag  <= 1'b1;
            idx_q <= idx;
        end else if (clr) begin
            flag  <= 1'b0;
            idx_q <= '0;
        end
    end
endmodule

// File: rtl/col_tracker.sv
module col_tracker
    import mac_evt_status_pkg::*;
#(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic done,
    input  logic col,
    input  logic past_min,
    output logic late,
    output logic excess
);
    localparam int CW = $clog2(LIMIT + 1);

    ct_state_t       state, nxt;
    logic [CW-1:0]   cnt, cnt_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= CT_IDLE;
            cnt   <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
        end
    end

    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        late    = 1'b0;
        excess  = 1'b0;
        unique case (state)
            CT_IDLE: begin
                if (start) begin
                    nxt     = CT_SEND;
                    cnt_nxt = '0;
                end
            end
            CT_SEND: begin
                if (done) begin
                    nxt = CT_IDLE;
                end else if (start) begin
                    cnt_nxt = '0;
                end else if (col) begin
                    late = past_min;
                    if (cnt == CW'(LIMIT - 1)) begin
                        excess = 1'b1;
                        nxt    = CT_GAVEUP;
                    end else begin
                        cnt_nxt = cnt + CW'(1);
                    end
                end
            end
            CT_GAVEUP: begin
                if (done) begin
                    nxt = CT_IDLE;
                end else if (start) begin
                    nxt     = CT_SEND;
                    cnt_nxt = '0;
                end
            end
            default: nxt = CT_IDLE;
        endcase
    end
endmodule

// File: rtl/mac_evt_status.sv
module mac_evt_status
    import mac_evt_status_pkg::*;
#(
    parameter int DSCR_W    = 8,
    parameter int COL_LIMIT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_stb,
    input  logic              pkt_end,
    input  logic              tx_start,
    input  logic [DSCR_W-1:0] dscr_cnt,
    input  logic [DSCR_W-1:0] hwm_lvl,
    input  logic [DSCR_W-1:0] lwm_lvl,
    input  logic              rxf_under,
    input  logic              rxf_over,
    input  logic              txf_under,
    input  logic              txf_over,
    input  logic              col_det,
    input  logic              past_min,
    input  logic              ctr_ovf,
    input  logic [IDX_W-1:0]  ctr_idx,
    output logic [STAT_W-1:0] status
);
    logic                late_p, exc_p;
    logic [N_STICKY-1:0] evt, flags;
    logic                ovf_flag;
    logic [IDX_W-1:0]    ovf_idx;

    col_tracker #(.LIMIT(COL_LIMIT)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (tx_start),
        .done     (pkt_end),
        .col      (col_det),
        .past_min (past_min),
        .late     (late_p),
        .excess   (exc_p)
    );

    assign evt = {exc_p, late_p, txf_over, txf_under, rxf_over, rxf_under, pkt_end};

    sticky_flags #(.N(N_STICKY)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rd_stb),
        .evt   (evt),
        .q     (flags)
    );

    ovf_capture u_ovf (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rd_stb),
        .ovf   (ctr_ovf),
        .idx   (ctr_idx),
        .flag  (ovf_flag),
        .idx_q (ovf_idx)
    );

    always_comb begin
        status                      = '0;
        status[B_EOP]               = flags[0];
        status[B_HWM]               = dscr_cnt < hwm_lvl;
        status[B_LWM]               = dscr_cnt < lwm_lvl;
        status[B_RXU]               = flags[1];
        status[B_RXO]               = flags[2];
        status[B_TXU]               = flags[3];
        status[B_TXO]               = flags[4];
        status[B_LATE]              = flags[5];
        status[B_EXC]               = flags[6];
        status[B_CTR]               = ovf_flag;
        status[IDX_LO +: IDX_W]     = ovf_idx;
    end
endmodule

// File: rtl/mac_evt_status_chk.sv
module mac_evt_status_chk
    import mac_evt_status_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input logic              pkt_end,
    input logic              rxf_over,
    input logic              ctr_ovf,
    input logic [IDX_W-1:0]  ctr_idx,
    input logic [STAT_W-1:0] status
);
    AST_EOP_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_end |=> status[B_EOP]);                                      // R3
    AST_RXO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        rxf_over |=> status[B_RXO]);                                     // R5
    AST_OVF_INDEX: assert property (@(posedge clk) disable iff (!rst_n)
        ctr_ovf |=> (status[B_CTR] && status[IDX_LO +: IDX_W] == $past(ctr_idx))); // R8
    AST_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !status[B_CTR] |-> status[IDX_LO +: IDX_W] == '0);               // R8
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !pkt_end) |=> !status[B_EOP]);                        // R9
    AST_READ_KEEPS_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && pkt_end) |=> status[B_EOP]);                          // R9
endmodule

bind mac_evt_status mac_evt_status_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_stb   (rd_stb),
    .pkt_end  (pkt_end),
    .rxf_over (rxf_over),
    .ctr_ovf  (ctr_ovf),
    .ctr_idx  (ctr_idx),
    .status   (status)
);

// File: tb/mac_evt_status_test.sv
`timescale 1ns/1ps
module mac_evt_status_test;
    localparam int W = 52;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_stb = 0, pkt_end = 0, tx_start = 0;
    logic [7:0]    dscr_cnt = 0, hwm_lvl = 0, lwm_lvl = 0;
    logic          rxf_under = 0, rxf_over = 0, txf_under = 0, txf_over = 0;
    logic          col_det = 0, past_min = 0, ctr_ovf = 0;
    logic [4:0]    ctr_idx = 0;
    logic [W-1:0]  status;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    mac_evt_status uut (
        .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .pkt_end(pkt_end),
        .tx_start(tx_start), .dscr_cnt(dscr_cnt), .hwm_lvl(hwm_lvl),
        .lwm_lvl(lwm_lvl), .rxf_under(rxf_under), .rxf_over(rxf_over),
        .txf_under(txf_under), .txf_over(txf_over), .col_det(col_det),
        .past_min(past_min), .ctr_ovf(ctr_ovf), .ctr_idx(ctr_idx),
        .status(status)
    );

    function automatic logic [W-1:0] bitw(int pos);
        logic [W-1:0] v = '0;
        v[pos] = 1'b1;
        return v;
    endfunction

    function automatic logic [W-1:0] idxw(logic [4:0] i);
        logic [W-1:0] v = '0;
        v[46] = 1'b1;
        v[51:47] = i;
        return v;
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_read();
        rd_stb = 1; step(); rd_stb = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; repeat (3) step(); rst_n = 1; step();
        chk("R1 reset", status, '0);
        chk("R2 reserved", {44'd0, status[39:32]}, '0);
    endtask

    task automatic t_eop();
        pkt_end = 1; step(); pkt_end = 0;
        chk("R3 set", status, bitw(0));
        step();
        chk("R3 held", status, bitw(0));
        do_read();
        chk("R3 cleared", status, '0);
    endtask

    task automatic t_live();
        dscr_cnt = 3; hwm_lvl = 8; lwm_lvl = 2; step();
        chk("R4 between", status, bitw(1));
        dscr_cnt = 1; step();
        chk("R4 below both", status, bitw(1) | bitw(2));
        do_read();
        chk("R4 read no effect", status, bitw(1) | bitw(2));
        dscr_cnt = 8; lwm_lvl = 8; step();
        chk("R4 equal", status, '0);
        dscr_cnt = 9; step();
        chk("R4 above", status, '0);
        dscr_cnt = 0; hwm_lvl = 0; lwm_lvl = 0;
    endtask

    task automatic t_fifo();
        rxf_under = 1; step(); rxf_under = 0;
        chk("R5 rx under", status, bitw(3));
        rxf_over = 1; step(); rxf_over = 0;
        chk("R5 rx over", status, bitw(3) | bitw(4));
        txf_under = 1; step(); txf_under = 0;
        txf_over = 1; step(); txf_over = 0;
        step();
        chk("R5 all four", status, bitw(3) | bitw(4) | bitw(5) | bitw(6));
        do_read();
        chk("R9 fifo cleared", status, '0);
    endtask

    task automatic t_late();
        tx_start = 1; step(); tx_start = 0;
        col_det = 1; past_min = 0; step(); col_det = 0;
        chk("R6 early collision", status, '0);
        col_det = 1; past_min = 1; step(); col_det = 0; past_min = 0;
        chk("R6 late collision", status, bitw(7));
        pkt_end = 1; step(); pkt_end = 0;
        do_read();
        chk("R9 late cleared", status, '0);
    endtask

    task automatic t_excess();
        tx_start = 1; step(); tx_start = 0;
        col_det = 1; repeat (15) step(); col_det = 0;
        chk("R7 fifteen", status, '0);
        col_det = 1; step(); col_det = 0;
        chk("R7 sixteenth", status, bitw(8));
        pkt_end = 1; step(); pkt_end = 0;
        do_read();
        chk("R7 cleared", status, '0);
        tx_start = 1; step(); tx_start = 0;
        col_det = 1; repeat (10) step(); col_det = 0;
        tx_start = 1; step(); tx_start = 0;
        col_det = 1; repeat (10) step(); col_det = 0;
        chk("R7 restart", status, '0);
        pkt_end = 1; step(); pkt_end = 0;
        do_read();
    endtask

    task automatic t_outside();
        col_det = 1; past_min = 1; repeat (20) step(); col_det = 0; past_min = 0;
        chk("R10 outside packet", status, '0);
    endtask

    task automatic t_ovf();
        ctr_ovf = 1; ctr_idx = 5; step(); ctr_ovf = 0;
        chk("R8 first", status, idxw(5'd5));
        ctr_ovf = 1; ctr_idx = 17; step(); ctr_ovf = 0;
        chk("R8 overwrite", status, idxw(5'd17));
        do_read();
        chk("R9 index cleared", status, '0);
    endtask

    task automatic t_same_cycle();
        rxf_under = 1; step(); rxf_under = 0;
        rd_stb = 1; pkt_end = 1; step(); rd_stb = 0; pkt_end = 0;
        chk("R9 event with read", status, bitw(0));
        do_read();
        ctr_ovf = 1; ctr_idx = 9; step(); ctr_ovf = 0;
        rd_stb = 1; ctr_ovf = 1; ctr_idx = 22; step(); rd_stb = 0; ctr_ovf = 0;
        chk("R9 overflow with read", status, idxw(5'd22));
        do_read();
        chk("R9 final clear", status, '0);
    endtask

    initial begin
        #(4 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_eop();
        t_live();
        t_fifo();
        t_late();
        t_excess();
        t_outside();
        t_ovf();
        t_same_cycle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule